// File: doc/BRIEF.md
# Calibration Run Median Selector

This block gathers the correction values produced by repeated calibration runs and reduces them to one robust value per correction register. Each run delivers five signed 16-bit corrections in a single word. After a configured number of runs (20 to 40) has been accepted, the block sorts each register's history in place with a bubble sort. A single compare-and-swap unit serves all five histories, one after another. It then presents the median of each history and raises a flag if the first correction drifted too much between runs.

The input is a valid/ready stream. `in_ready` is high only while runs are being collected. During the sort and the median pick it is low. Unlike a normal back-pressured stream, the source is not required to hold a word while `in_ready` is low. A word offered then is discarded, and the discard is tallied in a saturating counter. Results appear with a one-cycle `done_o` pulse and stay on the outputs until the next collection completes.

Top module: `cms_median_top`

## Requirements
- R1: The number of runs per collection is `run_count_i` limited to the range 20..40; values below 20 act as 20 and values above 40 act as 40. The count is captured when the first run of a collection is accepted, and later changes to `run_count_i` do not affect that collection.
- R2: Each register's history is put into ascending order by bubble passes through one shared compare-and-swap unit, and a pass that swaps nothing ends the sort of that register.
- R3: `done_o` is high for exactly one cycle per collection, after the last run has been accepted and all five histories are sorted. It never goes high before the last run of the collection is accepted.
- R4: The median for a register is the element at index (n-1)/2 of its ascending history (n runs). For an even n this is the lower of the two middle values. Register k occupies bits [16k+15:16k] of `in_data_i` and `med_o`.
- R5: Values are compared as two's-complement signed numbers, so negative corrections sort below positive ones.
- R6: `unstable_o` is 1 when the largest minus the smallest register-0 value of the collection exceeds 3. A spread of exactly 3 leaves it at 0.
- R7: `in_ready_o` is 1 while collecting and 0 from the cycle after the last run is accepted until `done_o` has been pulsed.
- R8: A word offered while `in_ready_o` is 0 is dropped, does not change any result, and increments `ovf_cnt_o` by one, saturating at its maximum value.
- R9: After reset `med_o`, `unstable_o`, `done_o` and `ovf_cnt_o` are 0 and `in_ready_o` is 1. The medians and flag keep their value from one `done_o` pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_count_i | input | 6 | Requested runs per collection |
| in_valid_i | input | 1 | A run's correction word is offered |
| in_ready_o | output | 1 | Block is collecting and accepts the word |
| in_data_i | input | 80 | Five signed 16-bit corrections of one run |
| med_o | output | 80 | Five signed 16-bit medians |
| unstable_o | output | 1 | Register-0 spread above 3 in last collection |
| done_o | output | 1 | One-cycle pulse when new medians are valid |
| ovf_cnt_o | output | 8 | Saturating count of dropped words |

## Verification
A run is taken on the rising edge where valid and ready are both high. `in_ready_o` is therefore already low at the falling edge after the last run. A dropped word shows up in `ovf_cnt_o` at the falling edge after the edge where it was offered. The sort takes a data-dependent number of cycles, so the bench does not predict the cycle of `done_o`. Instead it samples every falling edge until the pulse is seen, then compares the medians and the flag in that same half-cycle. It confirms on the next falling edge that the pulse has ended and that `in_ready_o` is high again. A falling-edge monitor counts every `done_o` pulse, which shows that no pulse arrives before a collection is complete.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [1:0] {
    PH_COLL = 2'd0,
    PH_SORT = 2'd1,
    PH_PICK = 2'd2
  } phase_t;
endpackage

// File: rtl/cms_cswap.sv
module cms_cswap #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  // signed order decides the swap (R5)
  assign gt_o = $signed(a_i) > $signed(b_i);
  assign lo_o = gt_o ? b_i : a_i;
  assign hi_o = gt_o ? a_i : b_i;
endmodule

// File: rtl/cms_run_buffer.sv
module cms_run_buffer #(
  parameter int W    = 16,
  parameter int NREG = 5,
  parameter int MAXR = 40,
  parameter int CW   = 6,
  parameter int RW   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en_i,
  input  logic [CW-1:0]                        wr_idx_i,
  input  logic [NREG*W-1:0]                    wr_data_i,
  input  logic                                 sw_en_i,
  input  logic [RW-1:0]                        sw_reg_i,
  input  logic [CW-1:0]                        sw_pos_i,
  input  logic [W-1:0]                         sw_lo_i,
  input  logic [W-1:0]                         sw_hi_i,
  output logic [W-1:0]                         rd_a_o,
  output logic [W-1:0]                         rd_b_o,
  output logic [NREG-1:0][MAXR-1:0][W-1:0]     arr_o
);
  logic [NREG-1:0][MAXR-1:0][W-1:0] mem_q;
  logic [CW-1:0] pos_nx;

  assign pos_nx = (sw_pos_i >= CW'(MAXR - 1)) ? sw_pos_i : sw_pos_i + CW'(1);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    for (genvar e = 0; e < MAXR; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[g][e] <= '0;
        end else if (wr_en_i && wr_idx_i == CW'(e)) begin
          mem_q[g][e] <= wr_data_i[g*W +: W];
        end else if (sw_en_i && sw_reg_i == RW'(g)) begin
          if (sw_pos_i == CW'(e))      mem_q[g][e] <= sw_lo_i;
          else if (pos_nx == CW'(e))   mem_q[g][e] <= sw_hi_i;
        end
      end
    end
  end

  assign rd_a_o = mem_q[sw_reg_i][sw_pos_i];
  assign rd_b_o = mem_q[sw_reg_i][pos_nx];
  assign arr_o  = mem_q;

  // after a swap the pair it touched is in ascending signed order
  logic          seen_q;
  logic [RW-1:0] sreg_q;
  logic [CW-1:0] spos_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      sreg_q <= '0;
      spos_q <= '0;
    end else begin
      seen_q <= sw_en_i;
      sreg_q <= sw_reg_i;
      spos_q <= sw_pos_i;
    end
  end

  assert_swap_orders_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> $signed(mem_q[sreg_q][spos_q]) <= $signed(mem_q[sreg_q][spos_q + CW'(1)]));
endmodule

// File: rtl/cms_sort_ctrl.sv
module cms_sort_ctrl
  import cms_pkg::*;
#(
  parameter int NREG = 5,
  parameter int MAXR = 40,
  parameter int MINR = 20,
  parameter int CW   = 6,
  parameter int RW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] run_count_i,
  input  logic          in_valid_i,
  input  logic          gt_i,
  output logic          in_ready_o,
  output logic          wr_en_o,
  output logic [CW-1:0] wr_idx_o,
  output logic          sw_en_o,
  output logic [RW-1:0] cmp_reg_o,
  output logic [CW-1:0] cmp_pos_o,
  output logic          pick_o,
  output logic [CW-1:0] n_o
);
  phase_t        ph_q;
  logic [CW-1:0] idx_q, j_q, lim_q, n_q, n_req, n_use;
  logic [RW-1:0] r_q;
  logic          swp_q;

  always_comb begin
    if (run_count_i < CW'(MINR))      n_req = CW'(MINR);
    else if (run_count_i > CW'(MAXR)) n_req = CW'(MAXR);
    else                              n_req = run_count_i;
  end

  assign n_use      = (idx_q == '0) ? n_req : n_q;
  assign in_ready_o = (ph_q == PH_COLL);
  assign wr_en_o    = in_ready_o && in_valid_i;
  assign wr_idx_o   = idx_q;
  assign sw_en_o    = (ph_q == PH_SORT) && gt_i;
  assign cmp_reg_o  = r_q;
  assign cmp_pos_o  = j_q;
  assign pick_o     = (ph_q == PH_PICK);
  assign n_o        = n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_COLL;
      idx_q <= '0;
      j_q   <= '0;
      lim_q <= CW'(1);
      n_q   <= CW'(MINR);
      r_q   <= '0;
      swp_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_COLL: if (in_valid_i) begin
          if (idx_q == '0) n_q <= n_req;
          if (idx_q == n_use - CW'(1)) begin
            ph_q  <= PH_SORT;
            idx_q <= '0;
            r_q   <= '0;
            j_q   <= '0;
            lim_q <= n_use - CW'(1);
            swp_q <= 1'b0;
          end else begin
            idx_q <= idx_q + CW'(1);
          end
        end
        PH_SORT: begin
          if (j_q == lim_q - CW'(1)) begin
            if ((!swp_q && !gt_i) || lim_q == CW'(1)) begin
              if (r_q == RW'(NREG - 1)) begin
                ph_q <= PH_PICK;
              end else begin
                r_q   <= r_q + RW'(1);
                lim_q <= n_q - CW'(1);
              end
            end else begin
              lim_q <= lim_q - CW'(1);
            end
            j_q   <= '0;
            swp_q <= 1'b0;
          end else begin
            j_q   <= j_q + CW'(1);
            swp_q <= swp_q | gt_i;
          end
        end
        default: ph_q <= PH_COLL;
      endcase
    end
  end

  assert_runs_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q >= CW'(MINR)) && (n_q <= CW'(MAXR)));

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SORT) |-> (j_q < lim_q) && (lim_q < n_q));
endmodule

// File: rtl/cms_median_top.sv
module cms_median_top #(
  parameter int W    = 16,
  parameter int NREG = 5,
  parameter int MINR = 20,
  parameter int MAXR = 40,
  parameter int THR  = 3,
  parameter int OVW  = 8,
  localparam int CW  = $clog2(MAXR + 1),
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     run_count_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [NREG*W-1:0] in_data_i,
  output logic [NREG*W-1:0] med_o,
  output logic              unstable_o,
  output logic              done_o,
  output logic [OVW-1:0]    ovf_cnt_o
);
  logic                             wr_en, sw_en, gt, pick;
  logic [CW-1:0]                    wr_idx, cmp_pos, n_cur, mid, last;
  logic [RW-1:0]                    cmp_reg;
  logic [W-1:0]                     rd_a, rd_b, lo, hi;
  logic [NREG-1:0][MAXR-1:0][W-1:0] arr;
  logic [NREG*W-1:0]                med_q;
  logic                             uns_q, done_q;
  logic [OVW-1:0]                   ovf_q;
  logic signed [W:0]                spread;

  cms_sort_ctrl #(.NREG(NREG), .MAXR(MAXR), .MINR(MINR), .CW(CW), .RW(RW)) u_ctrl (
    .clk, .rst_n, .run_count_i, .in_valid_i, .gt_i(gt),
    .in_ready_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .sw_en_o(sw_en),
    .cmp_reg_o(cmp_reg), .cmp_pos_o(cmp_pos), .pick_o(pick), .n_o(n_cur)
  );

  cms_run_buffer #(.W(W), .NREG(NREG), .MAXR(MAXR), .CW(CW), .RW(RW)) u_buf (
    .clk, .rst_n, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(in_data_i),
    .sw_en_i(sw_en), .sw_reg_i(cmp_reg), .sw_pos_i(cmp_pos),
    .sw_lo_i(lo), .sw_hi_i(hi), .rd_a_o(rd_a), .rd_b_o(rd_b), .arr_o(arr)
  );

  cms_cswap #(.W(W)) u_cas (
    .a_i(rd_a), .b_i(rd_b), .gt_o(gt), .lo_o(lo), .hi_o(hi)
  );

  assign last   = n_cur - CW'(1);
  assign mid    = last >> 1;
  assign spread = $signed({arr[0][last][W-1], arr[0][last]})
                - $signed({arr[0][0][W-1], arr[0][0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      med_q  <= '0;
      uns_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= '0;
    end else begin
      done_q <= pick;
      if (pick) begin
        for (int k = 0; k < NREG; k++) med_q[k*W +: W] <= arr[k][mid];
        uns_q <= (spread > (W+1)'(THR));
      end
      if (in_valid_i && !in_ready_o && ovf_q != '1) ovf_q <= ovf_q + OVW'(1);
    end
  end

  assign med_o      = med_q;
  assign unstable_o = uns_q;
  assign done_o     = done_q;
  assign ovf_cnt_o  = ovf_q;

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_ovf_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !in_ready_o && ovf_q != '1) |=> ovf_q == $past(ovf_q) + OVW'(1));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pick |=> $stable(med_q) && $stable(uns_q));

  assert_ready_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> in_ready_o);
endmodule

// File: tb/tb_cms_median_top.sv
module tb_cms_median_top;
  localparam int W = 16, NREG = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    run_count_i = 6'd20;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [79:0]   in_data_i = '0;
  logic [79:0]   med_o;
  logic          unstable_o, done_o;
  logic [7:0]    ovf_cnt_o;

  int checks = 0, errs = 0, done_cnt = 0;
  bit finished = 0;
  int vals [NREG][40];

  always #2.5 clk = ~clk;

  cms_median_top dut (
    .clk, .rst_n, .run_count_i, .in_valid_i, .in_ready_o, .in_data_i,
    .med_o, .unstable_o, .done_o, .ovf_cnt_o
  );

  always @(negedge clk) if (done_o) done_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int median_of(input int k, input int n);
    int s [40];
    for (int i = 0; i < n; i++) s[i] = vals[k][i];
    for (int i = 1; i < n; i++) begin
      int t = s[i];
      int p = i - 1;
      while (p >= 0 && s[p] > t) begin s[p+1] = s[p]; p--; end
      s[p+1] = t;
    end
    return s[(n-1)/2];
  endfunction

  function automatic int spread0(input int n);
    int mn = vals[0][0], mx = vals[0][0];
    for (int i = 1; i < n; i++) begin
      if (vals[0][i] < mn) mn = vals[0][i];
      if (vals[0][i] > mx) mx = vals[0][i];
    end
    return mx - mn;
  endfunction

  function automatic int gen(input int mode, input int k, input int i, input int base);
    int v;
    case (mode)
      1: v = (k == 0) ? base + ((i == 0) ? 0 : (i == 1) ? 3 : int'($urandom % 4))
                      : int'($urandom % 2001) - 1000;
      2: v = (k == 0) ? base + ((i == 0) ? 0 : (i == 1) ? 4 : int'($urandom % 5))
                      : int'($urandom % 2001) - 1000;
      3: v = int'($urandom % 16) - 8;
      default: v = int'($signed(16'($urandom)));
    endcase
    return v;
  endfunction

  task automatic run_trial(input int cfg, input int n, input int mode, input int poke,
                           input bit hold_chk);
    int base = int'($urandom % 2001) - 1000;
    int ovf0, d0, wd;
    run_count_i = 6'(cfg);
    d0 = done_cnt;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < NREG; k++) begin
        vals[k][i] = gen(mode, k, i, base);
        in_data_i[k*W +: W] = 16'(vals[k][i]);
      end
      if (i == 0) chk("R7 ready while collecting", int'(in_ready_o), 1);
      in_valid_i = 1'b1;
      @(negedge clk);
      in_valid_i = 1'b0;
      if (i == 2) run_count_i = 6'($urandom % 64);
    end
    chk("R3 no done before last run", done_cnt - d0, 0);
    chk("R7 ready low after last run", int'(in_ready_o), 0);
    ovf0 = int'(ovf_cnt_o);
    for (int p = 0; p < poke; p++) begin
      in_valid_i = 1'b1;
      in_data_i = {5{16'h7fff}};
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    if (poke > 0) chk("R8 dropped words counted", int'(ovf_cnt_o), ovf0 + poke);
    wd = 0;
    while (!done_o && wd < 20000) begin @(negedge clk); wd++; end
    chk("R3 done reached", int'(done_o), 1);
    for (int k = 0; k < NREG; k++)
      chk(k == 0 ? "R4 R5 R1 median reg0" : "R4 R2 R5 median",
          int'($signed(med_o[k*W +: W])), median_of(k, n));
    chk("R6 unstable flag", int'(unstable_o), (spread0(n) > 3) ? 1 : 0);
    @(negedge clk);
    chk("R3 done is one pulse", int'(done_o), 0);
    chk("R3 one pulse per collection", done_cnt - d0, 1);
    chk("R7 ready after done", int'(in_ready_o), 1);
    if (hold_chk) begin
      repeat (7) @(negedge clk);
      for (int k = 0; k < NREG; k++)
        chk("R9 medians held", int'($signed(med_o[k*W +: W])), median_of(k, n));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c4a));
    repeat (3) @(negedge clk);
    chk("R9 reset med", int'(med_o != '0), 0);
    chk("R9 reset done", int'(done_o), 0);
    chk("R9 reset unstable", int'(unstable_o), 0);
    chk("R9 reset ovf", int'(ovf_cnt_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready after reset", int'(in_ready_o), 1);
    run_trial(20, 20, 1, 3, 1'b1);  // spread exactly 3, even count
    run_trial(21, 21, 2, 0, 1'b0);  // spread 4, odd count
    run_trial(5, 20, 3, 2, 1'b0);   // R1 low clamp, duplicates, negatives
    run_trial(63, 40, 0, 1, 1'b0);  // R1 high clamp, full range
    run_trial(40, 40, 1, 0, 1'b0);
    run_trial(30, 30, 3, 0, 1'b1);
    for (int t = 0; t < 4; t++) begin
      int c = 20 + int'($urandom % 21);
      run_trial(c, c, int'($urandom % 4), int'($urandom % 3), 1'b0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule